// File: doc/BRIEF.md
# Control Endpoint SETUP Capture

This block sits behind the packet engine of a device-mode USB control OUT endpoint. When a SETUP transaction arrives with its 8-byte payload, the block stages it into a shared receive FIFO as three 32-bit entries. It counts the packet down in a 2-bit SETUP counter that software programs beforehand, and it forces the endpoint into NAK with the OUT enable cleared. When the transfer leaves the Setup stage, it appends one stage-done entry. Software drains the FIFO through a pop strobe and a head-of-queue word. The endpoint interrupt is raised only when software pops the stage-done entry. Software then reads the remaining counter value to learn how many SETUP packets arrived, and acts on the last one.

Ordinary OUT data words share the same FIFO. A fixed number of entries is kept back for SETUP traffic, so data is accepted only while more than that reserve is free. SETUP words ignore both the reserve and the endpoint handshake state.

A sequencer drives the SETUP writes. Its states and transitions:
- `ST_IDLE` moves to `ST_STATUS` on an accepted SETUP.
- `ST_STATUS` moves to `ST_LOW`, which moves to `ST_HIGH`. Each of these three states writes one entry.
- `ST_HIGH` moves to `ST_OPEN`.
- In `ST_OPEN`, a further SETUP goes back to `ST_STATUS`, and a stage change goes to `ST_DONE`.
- `ST_DONE` writes the stage-done entry and moves to `ST_IDLE`.

Top module: `ctl_setup_capture`

## Requirements
- R1: An accepted SETUP writes three entries in three consecutive cycles, in this order:
  - a status word `{16'h0, byte_count=8'd8, type=4'h6, ep_number[3:0]}`;
  - payload bytes 0..3 (`setup_data[31:0]`, byte n at bits 8n+7:8n);
  - payload bytes 4..7 (`setup_data[63:32]`).
- R2: Each accepted SETUP lowers the 2-bit SETUP counter by one on the next edge. At 0 the counter holds at 0, and the packet is still written.
- R3: A software counter write loads `sw_cnt_wdata` on the next edge. If it coincides with an accepted SETUP, the software value wins.
- R4: A stage-change pulse while a Setup stage is open (`ST_OPEN`) writes one stage-done word `{16'h0, 8'd0, type=4'h4, ep_number}` after the SETUP entries. A stage-change pulse at any other time writes nothing.
- R5: `stup_irq` rises only on the edge where software pops a stage-done entry. It does not rise when SETUP data or the stage-done entry is written.
- R6: `stup_irq` stays set until a `stup_clr` pulse clears it. If a pop of a stage-done entry and `stup_clr` fall in the same cycle, the interrupt is set.
- R7: On the edge after an accepted SETUP, `ep_in_nak` and `ep_out_nak` read 1 and `ep_out_en` reads 0. This overrides any software endpoint-control write in the same cycle.
- R8: Data words reach the FIFO only through `out_ready`, and only in the cycle they are pushed. `out_ready` is 1 only while more than `RESV` entries are free and no SETUP entry is being written. Accepted data words are popped in order.
- R9: SETUP and stage-done entries are written even while `out_ready` is 0. Entries that find the FIFO physically full are lost.
- R10: `rx_nonempty` is 1 whenever the FIFO holds at least one entry, and 0 when it is empty.
- R11: A SETUP pulse that arrives while entries are being written (`ST_STATUS`, `ST_LOW`, `ST_HIGH`, `ST_DONE`) is ignored. It adds no entries and does not change the counter.
- R12: Synchronous reset empties the FIFO and clears the counter, the interrupt, both NAK bits and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| setup_valid | input | 1 | SETUP packet received (one-cycle pulse) |
| setup_data | input | 64 | SETUP payload, byte n at bits 8n+7:8n |
| stage_change | input | 1 | Transfer moved to a data stage (pulse) |
| out_push | input | 1 | Ordinary OUT data word offered |
| out_word | input | 32 | Ordinary OUT data word |
| out_ready | output | 1 | Data word may be accepted this cycle |
| sw_pop | input | 1 | Software pops the head entry |
| sw_rdata | output | 32 | Head entry of the FIFO |
| rx_nonempty | output | 1 | FIFO holds at least one entry |
| sw_cnt_wr | input | 1 | Software writes the SETUP counter |
| sw_cnt_wdata | input | 2 | Counter value to write |
| setup_cnt | output | 2 | Remaining SETUP counter |
| sw_epctl_wr | input | 1 | Software writes endpoint control |
| sw_epctl_nak | input | 1 | NAK value for both directions |
| sw_epctl_en | input | 1 | OUT enable value |
| ep_in_nak | output | 1 | IN NAK state |
| ep_out_nak | output | 1 | OUT NAK state |
| ep_out_en | output | 1 | OUT endpoint enable |
| stup_irq | output | 1 | SETUP-complete interrupt |
| stup_clr | input | 1 | Write-1-to-clear for the interrupt |

## Verification
Two pairs of events can land on the same edge, and the bench forces each one directly.

The first pair is the interrupt set and the interrupt clear. The bench pulses `stup_clr` in the very cycle it pops a stage-done entry, and expects `stup_irq` to read 1 afterwards.

The second pair is the counter decrement and a software counter load. The bench raises `setup_valid` together with `sw_cnt_wr`, and expects the written value rather than that value minus one.

Around these collisions, the bench sweeps one to four back-to-back SETUPs. For each run it computes the saturating counter value and the full entry sequence arithmetically, then compares every popped word against them.

// File: rtl/ctl_setup_pkg.sv
package ctl_setup_pkg;

    typedef enum logic [1:0] {
        EK_DATA,
        EK_STATUS,
        EK_PAYLOAD,
        EK_DONE
    } entry_kind_e;

    typedef struct packed {
        entry_kind_e kind;
        logic [31:0] word;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STATUS,
        ST_LOW,
        ST_HIGH,
        ST_OPEN,
        ST_DONE
    } seq_state_e;

    localparam int          SU_CNT_W      = 2;
    localparam logic [3:0]  PT_SETUP_DATA = 4'h6;
    localparam logic [3:0]  PT_STAGE_DONE = 4'h4;
    localparam logic [7:0]  SETUP_BYTES   = 8'd8;

    function automatic logic [31:0] status_word(
        input logic [3:0] ep,
        input logic [3:0] pkt_type,
        input logic [7:0] byte_cnt
    );
        return {16'h0000, byte_cnt, pkt_type, ep};
    endfunction

endpackage

// File: rtl/ctl_setup_fifo.sv
module ctl_setup_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 34,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ctl_setup_seq.sv
module ctl_setup_seq
    import ctl_setup_pkg::*;
#(
    parameter int EP_ID = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        setup_valid,
    input  logic [63:0] setup_data,
    input  logic        stage_change,
    output logic        setup_acc,
    output logic        push,
    output rx_entry_t   entry
);

    localparam logic [3:0] EP_NUM = 4'(EP_ID);

    seq_state_e  state;
    seq_state_e  state_nx;
    logic [63:0] pay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (setup_acc) begin
            pay_q <= setup_data;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (setup_valid)       state_nx = ST_STATUS;
            ST_STATUS:                        state_nx = ST_LOW;
            ST_LOW:                           state_nx = ST_HIGH;
            ST_HIGH:                          state_nx = ST_OPEN;
            ST_OPEN: begin
                if (setup_valid)              state_nx = ST_STATUS;
                else if (stage_change)        state_nx = ST_DONE;
            end
            ST_DONE:                          state_nx = ST_IDLE;
            default:                          state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        setup_acc  = 1'b0;
        push       = 1'b0;
        entry.kind = EK_DATA;
        entry.word = '0;
        unique case (state)
            ST_IDLE: setup_acc = setup_valid;
            ST_OPEN: setup_acc = setup_valid;
            ST_STATUS: begin
                push       = 1'b1;
                entry.kind = EK_STATUS;
                entry.word = status_word(EP_NUM, PT_SETUP_DATA, SETUP_BYTES);
            end
            ST_LOW: begin
                push       = 1'b1;
                entry.kind = EK_PAYLOAD;
                entry.word = pay_q[31:0];
            end
            ST_HIGH: begin
                push       = 1'b1;
                entry.kind = EK_PAYLOAD;
                entry.word = pay_q[63:32];
            end
            ST_DONE: begin
                push       = 1'b1;
                entry.kind = EK_DONE;
                entry.word = status_word(EP_NUM, PT_STAGE_DONE, 8'd0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctl_setup_epstate.sv
module ctl_setup_epstate
    import ctl_setup_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                setup_acc,
    input  logic                sw_cnt_wr,
    input  logic [SU_CNT_W-1:0] sw_cnt_wdata,
    input  logic                sw_epctl_wr,
    input  logic                sw_epctl_nak,
    input  logic                sw_epctl_en,
    input  logic                done_popped,
    input  logic                stup_clr,
    output logic [SU_CNT_W-1:0] setup_cnt,
    output logic                ep_in_nak,
    output logic                ep_out_nak,
    output logic                ep_out_en,
    output logic                stup_irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_cnt <= '0;
        end else if (sw_cnt_wr) begin
            setup_cnt <= sw_cnt_wdata;
        end else if (setup_acc && (setup_cnt != '0)) begin
            setup_cnt <= setup_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_in_nak  <= 1'b0;
            ep_out_nak <= 1'b0;
            ep_out_en  <= 1'b0;
        end else if (setup_acc) begin
            ep_in_nak  <= 1'b1;
            ep_out_nak <= 1'b1;
            ep_out_en  <= 1'b0;
        end else if (sw_epctl_wr) begin
            ep_in_nak  <= sw_epctl_nak;
            ep_out_nak <= sw_epctl_nak;
            ep_out_en  <= sw_epctl_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stup_irq <= 1'b0;
        end else begin
            stup_irq <= done_popped || (stup_irq && !stup_clr);
        end
    end

endmodule

// File: rtl/ctl_setup_capture.sv
module ctl_setup_capture
    import ctl_setup_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RESV  = 10,
    parameter int EP_ID = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        setup_valid,
    input  logic [63:0] setup_data,
    input  logic        stage_change,
    input  logic        out_push,
    input  logic [31:0] out_word,
    output logic        out_ready,
    input  logic        sw_pop,
    output logic [31:0] sw_rdata,
    output logic        rx_nonempty,
    input  logic        sw_cnt_wr,
    input  logic [1:0]  sw_cnt_wdata,
    output logic [1:0]  setup_cnt,
    input  logic        sw_epctl_wr,
    input  logic        sw_epctl_nak,
    input  logic        sw_epctl_en,
    output logic        ep_in_nak,
    output logic        ep_out_nak,
    output logic        ep_out_en,
    output logic        stup_irq,
    input  logic        stup_clr
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = $bits(rx_entry_t);

    logic          setup_acc;
    logic          seq_push;
    rx_entry_t     seq_entry;
    logic          data_acc;
    rx_entry_t     wr_entry;
    rx_entry_t     head;
    logic [CW-1:0] fifo_count;
    logic [CW-1:0] free_slots;
    logic          done_popped;

    ctl_setup_seq #(.EP_ID(EP_ID)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .setup_valid  (setup_valid),
        .setup_data   (setup_data),
        .stage_change (stage_change),
        .setup_acc    (setup_acc),
        .push         (seq_push),
        .entry        (seq_entry)
    );

    assign free_slots = CW'(DEPTH) - fifo_count;
    assign out_ready  = (free_slots > CW'(RESV)) && !seq_push;
    assign data_acc   = out_push && out_ready;

    always_comb begin
        if (seq_push) begin
            wr_entry = seq_entry;
        end else begin
            wr_entry.kind = EK_DATA;
            wr_entry.word = out_word;
        end
    end

    ctl_setup_fifo #(.DEPTH(DEPTH), .WIDTH(EW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (seq_push || data_acc),
        .wdata (wr_entry),
        .pop   (sw_pop),
        .rdata (head),
        .count (fifo_count)
    );

    assign sw_rdata    = head.word;
    assign rx_nonempty = (fifo_count != '0);
    assign done_popped = sw_pop && rx_nonempty && (head.kind == EK_DONE);

    ctl_setup_epstate u_ep (
        .clk          (clk),
        .rst          (rst),
        .setup_acc    (setup_acc),
        .sw_cnt_wr    (sw_cnt_wr),
        .sw_cnt_wdata (sw_cnt_wdata),
        .sw_epctl_wr  (sw_epctl_wr),
        .sw_epctl_nak (sw_epctl_nak),
        .sw_epctl_en  (sw_epctl_en),
        .done_popped  (done_popped),
        .stup_clr     (stup_clr),
        .setup_cnt    (setup_cnt),
        .ep_in_nak    (ep_in_nak),
        .ep_out_nak   (ep_out_nak),
        .ep_out_en    (ep_out_en),
        .stup_irq     (stup_irq)
    );

endmodule

// File: rtl/ctl_setup_capture_chk.sv
module ctl_setup_capture_chk (
    input logic       clk,
    input logic       rst,
    input logic       setup_acc,
    input logic       sw_cnt_wr,
    input logic [1:0] sw_cnt_wdata,
    input logic [1:0] setup_cnt,
    input logic       sw_pop,
    input logic       stup_irq,
    input logic       stup_clr,
    input logic       ep_in_nak,
    input logic       ep_out_nak,
    input logic       ep_out_en
);

    AST_CNT_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (setup_acc && !sw_cnt_wr && setup_cnt != 2'd0) |=> (setup_cnt == $past(setup_cnt) - 2'd1)); // R2

    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (setup_cnt == 2'd0 && !sw_cnt_wr) |=> (setup_cnt == 2'd0)); // R2

    AST_CNT_SW_LOAD: assert property (@(posedge clk) disable iff (rst)
        sw_cnt_wr |=> (setup_cnt == $past(sw_cnt_wdata))); // R3

    AST_IRQ_FROM_POP: assert property (@(posedge clk) disable iff (rst)
        $rose(stup_irq) |-> $past(sw_pop)); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stup_irq && !stup_clr) |=> stup_irq); // R6

    AST_SETUP_FORCES_NAK: assert property (@(posedge clk) disable iff (rst)
        setup_acc |=> (ep_in_nak && ep_out_nak && !ep_out_en)); // R7

endmodule

bind ctl_setup_capture ctl_setup_capture_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .setup_acc    (setup_acc),
    .sw_cnt_wr    (sw_cnt_wr),
    .sw_cnt_wdata (sw_cnt_wdata),
    .setup_cnt    (setup_cnt),
    .sw_pop       (sw_pop),
    .stup_irq     (stup_irq),
    .stup_clr     (stup_clr),
    .ep_in_nak    (ep_in_nak),
    .ep_out_nak   (ep_out_nak),
    .ep_out_en    (ep_out_en)
);

// File: tb/ctl_setup_capture_tb.sv
module ctl_setup_capture_tb;

    localparam logic [31:0] W_STATUS = 32'h0000_0860;
    localparam logic [31:0] W_DONE   = 32'h0000_0040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        setup_valid = 1'b0;
    logic [63:0] setup_data = '0;
    logic        stage_change = 1'b0;
    logic        out_push = 1'b0;
    logic [31:0] out_word = '0;
    logic        out_ready;
    logic        sw_pop = 1'b0;
    logic [31:0] sw_rdata;
    logic        rx_nonempty;
    logic        sw_cnt_wr = 1'b0;
    logic [1:0]  sw_cnt_wdata = '0;
    logic [1:0]  setup_cnt;
    logic        sw_epctl_wr = 1'b0;
    logic        sw_epctl_nak = 1'b0;
    logic        sw_epctl_en = 1'b0;
    logic        ep_in_nak;
    logic        ep_out_nak;
    logic        ep_out_en;
    logic        stup_irq;
    logic        stup_clr = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ctl_setup_capture u_dut (
        .clk(clk), .rst(rst), .setup_valid(setup_valid), .setup_data(setup_data),
        .stage_change(stage_change), .out_push(out_push), .out_word(out_word),
        .out_ready(out_ready), .sw_pop(sw_pop), .sw_rdata(sw_rdata),
        .rx_nonempty(rx_nonempty), .sw_cnt_wr(sw_cnt_wr), .sw_cnt_wdata(sw_cnt_wdata),
        .setup_cnt(setup_cnt), .sw_epctl_wr(sw_epctl_wr), .sw_epctl_nak(sw_epctl_nak),
        .sw_epctl_en(sw_epctl_en), .ep_in_nak(ep_in_nak), .ep_out_nak(ep_out_nak),
        .ep_out_en(ep_out_en), .stup_irq(stup_irq), .stup_clr(stup_clr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic prog(input logic [1:0] cnt);
        sw_cnt_wr = 1'b1; sw_cnt_wdata = cnt;
        sw_epctl_wr = 1'b1; sw_epctl_nak = 1'b0; sw_epctl_en = 1'b1;
        step();
        sw_cnt_wr = 1'b0; sw_epctl_wr = 1'b0; sw_epctl_en = 1'b0;
    endtask

    task automatic send_setup(input logic [63:0] d);
        setup_valid = 1'b1; setup_data = d;
        step();
        setup_valid = 1'b0;
        repeat (3) step();
    endtask

    task automatic close_stage();
        stage_change = 1'b1;
        step();
        stage_change = 1'b0;
        step();
    endtask

    task automatic pop_expect(input string req, input logic [31:0] exp);
        chk(req, {32'h0, sw_rdata}, {32'h0, exp});
        sw_pop = 1'b1;
        step();
        sw_pop = 1'b0;
    endtask

    task automatic clear_irq();
        stup_clr = 1'b1;
        step();
        stup_clr = 1'b0;
    endtask

    function automatic logic [63:0] pat(input int n, input int k);
        return {32'hC300_0000 | 32'(n << 8) | 32'(k), 32'h5A00_0000 | 32'(n << 8) | 32'(k)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        // R12: state after reset
        chk("R12 nonempty", {63'h0, rx_nonempty}, 64'h0);
        chk("R12 cnt",      {62'h0, setup_cnt}, 64'h0);
        chk("R12 irq",      {63'h0, stup_irq}, 64'h0);
        chk("R12 nak/en",   {61'h0, ep_in_nak, ep_out_nak, ep_out_en}, 64'h0);
        chk("R8 ready idle", {63'h0, out_ready}, 64'h1);

        // Sweep over 1..4 back-to-back SETUPs
        for (int n = 1; n <= 4; n++) begin
            prog(2'd3);
            for (int k = 0; k < n; k++) begin
                send_setup(pat(n, k));
                if (k == 0) begin
                    chk("R7 nak/en", {61'h0, ep_in_nak, ep_out_nak, ep_out_en}, 64'h6);
                    chk("R5 no irq on arrival", {63'h0, stup_irq}, 64'h0);
                end
            end
            close_stage();
            chk("R2 counter", {62'h0, setup_cnt}, 64'((n >= 3) ? 0 : 3 - n));
            chk("R10 nonempty", {63'h0, rx_nonempty}, 64'h1);
            chk("R5 no irq before pop", {63'h0, stup_irq}, 64'h0);
            for (int k = 0; k < n; k++) begin
                pop_expect("R1 status", W_STATUS);
                pop_expect("R1 low",    pat(n, k)[31:0]);
                pop_expect("R1 high",   pat(n, k)[63:32]);
            end
            chk("R5 irq not on data pop", {63'h0, stup_irq}, 64'h0);
            pop_expect("R4 done word", W_DONE);
            chk("R5 irq on done pop", {63'h0, stup_irq}, 64'h1);
            chk("R10 empty", {63'h0, rx_nonempty}, 64'h0);
            clear_irq();
            chk("R6 clear", {63'h0, stup_irq}, 64'h0);
        end

        // R3: software write wins over decrement
        prog(2'd3);
        setup_valid = 1'b1; setup_data = pat(7, 1);
        sw_cnt_wr = 1'b1; sw_cnt_wdata = 2'd1;
        step();
        setup_valid = 1'b0; sw_cnt_wr = 1'b0;
        chk("R3 sw wins", {62'h0, setup_cnt}, 64'h1);
        chk("R8 not ready while writing", {63'h0, out_ready}, 64'h0);
        repeat (3) step();
        close_stage();
        pop_expect("R1 status", W_STATUS);
        pop_expect("R1 low", pat(7, 1)[31:0]);
        pop_expect("R1 high", pat(7, 1)[63:32]);
        pop_expect("R4 done word", W_DONE);
        clear_irq();

        // R6: set wins over same-cycle clear
        send_setup(pat(8, 0));
        close_stage();
        repeat (3) begin
            sw_pop = 1'b1; step(); sw_pop = 1'b0;
        end
        stup_clr = 1'b1;
        pop_expect("R4 done word", W_DONE);
        stup_clr = 1'b0;
        chk("R6 set wins", {63'h0, stup_irq}, 64'h1);
        clear_irq();

        // R4: stage change with no open Setup stage
        close_stage();
        chk("R4 ignored when idle", {63'h0, rx_nonempty}, 64'h0);

        // R11: SETUP during write ignored
        prog(2'd3);
        setup_valid = 1'b1; setup_data = pat(9, 0);
        step();
        setup_valid = 1'b0;
        step();
        setup_valid = 1'b1; setup_data = pat(9, 5);
        step();
        setup_valid = 1'b0;
        step();
        close_stage();
        chk("R11 counter once", {62'h0, setup_cnt}, 64'h2);
        pop_expect("R11 status", W_STATUS);
        pop_expect("R11 low", pat(9, 0)[31:0]);
        pop_expect("R11 high", pat(9, 0)[63:32]);
        pop_expect("R11 done follows", W_DONE);
        chk("R11 empty", {63'h0, rx_nonempty}, 64'h0);
        clear_irq();

        // R8/R9: reserve and SETUP writes past it
        prog(2'd3);
        for (int i = 0; i < 8; i++) begin
            out_push = 1'b1; out_word = 32'hD000_0000 + 32'(i);
            step();
        end
        out_push = 1'b0;
        chk("R8 ready low at reserve", {63'h0, out_ready}, 64'h0);
        send_setup(pat(10, 0));
        close_stage();
        for (int i = 0; i < 6; i++) begin
            pop_expect("R8 data order", 32'hD000_0000 + 32'(i));
        end
        pop_expect("R9 status", W_STATUS);
        pop_expect("R9 low", pat(10, 0)[31:0]);
        pop_expect("R9 high", pat(10, 0)[63:32]);
        pop_expect("R9 done", W_DONE);
        chk("R10 empty", {63'h0, rx_nonempty}, 64'h0);
        clear_irq();

        // R12: mid-run reset
        prog(2'd3);
        send_setup(pat(11, 0));
        close_stage();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R12 flush", {63'h0, rx_nonempty}, 64'h0);
        chk("R12 cnt clear", {62'h0, setup_cnt}, 64'h0);
        chk("R12 nak/en clear", {61'h0, ep_in_nak, ep_out_nak, ep_out_en}, 64'h0);

        finish_run();
    end

endmodule